// File: doc/BRIEF.md
# Compare Action Pin Driver

This block sets the level of one capture/compare output pin from the events of a timer. A counter elsewhere issues a one-cycle start pulse when the timer is enabled and a one-cycle time-out pulse each time it expires. This block turns those pulses into pin transitions according to a 3-bit action code. Some codes act only on time-outs: they hold the pin, toggle it, set it or clear it. The other codes first force the pin to a known level when the start pulse arrives, then act on every later time-out.

The pin is registered. A polarity input inverts what reaches the pin without disturbing the internal level. The action code is read only when an event arrives, so software can reprogram it while the timer runs.

Top module: `cmp_action_out`

## Requirements
- R1: While `rst` is high at a clock edge, the internal level and `pin_o` become 0 after that edge, whatever `inv_i` is.
- R2: With action code 0, neither time-out nor start pulses change the pin.
- R3: With action code 1, every time-out inverts the pin, and a start pulse alone has no effect.
- R4: With action code 2, a time-out drives the pin to 0. With code 3, a time-out drives it to 1. For codes 0 to 3, start is ignored.
- R5: Code 4 drives the pin to 1 on start and code 5 drives it to 0 on start. With either code, each later time-out inverts it.
- R6: Code 6 drives the pin to 1 on start and to 0 on each time-out. Code 7 drives it to 0 on start and to 1 on each time-out.
- R7: When start and time-out are high in the same cycle under codes 4 to 7, only the start action is applied. Under codes 1 to 3, the time-out action is applied.
- R8: A change of the action code with no event pending leaves the pin unchanged. The new code governs the next event.
- R9: When `inv_i` is 1, `pin_o` is the complement of the internal level. A change of `inv_i` reaches the pin after one clock edge.
- R10: `pin_o` changes at the first rising edge that samples an event pulse high, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| act_sel | input | 3 | Action code (0 to 7, as in R2 to R6) |
| start_i | input | 1 | One-cycle pulse when the timer is enabled |
| tmo_i | input | 1 | One-cycle time-out pulse |
| inv_i | input | 1 | 1 = pin polarity inverted |
| pin_o | output | 1 | Registered pin level |

## Verification
Start and time-out can fall in the same cycle, and in that case one action must be taken and the other dropped. The bench raises both pulses in one cycle under codes 4 and 5. It first sets the level so that obeying the time-out would give the opposite of the start level, so either error shows up as a pin mismatch. It repeats the collision under code 1 to show that a code without a start action still toggles.

// File: rtl/cmp_act_pkg.sv
package cmp_act_pkg;
  localparam int ACT_W = 3;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } pin_op_e;
endpackage

// File: rtl/cmp_act_decode.sv
module cmp_act_decode
  import cmp_act_pkg::*;
(
  input  logic [ACT_W-1:0] act_sel,
  input  logic             start_i,
  input  logic             tmo_i,
  output pin_op_e          op_o
);
  // Codes with the top bit set force a level at start; bit 0 picks it.
  logic has_start_act;
  assign has_start_act = act_sel[ACT_W-1];

  always_comb begin
    op_o = OP_HOLD;
    if (start_i && has_start_act) begin
      op_o = act_sel[0] ? OP_CLR : OP_SET;
    end else if (tmo_i) begin
      unique case (act_sel)
        3'd0:                op_o = OP_HOLD;
        3'd1, 3'd4, 3'd5:    op_o = OP_TOG;
        3'd2, 3'd6:          op_o = OP_CLR;
        default:             op_o = OP_SET;
      endcase
    end
  end
endmodule

// File: rtl/cmp_act_level.sv
module cmp_act_level
  import cmp_act_pkg::*;
#(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  pin_op_e op_i,
  input  logic    inv_i,
  output logic    level_o,
  output logic    pin_o
);
  logic level_q;
  logic level_d;
  logic pin_q;

  always_comb begin
    unique case (op_i)
      OP_SET:  level_d = 1'b1;
      OP_CLR:  level_d = 1'b0;
      OP_TOG:  level_d = ~level_q;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= RST_LEVEL;
      pin_q   <= RST_LEVEL;
    end else begin
      level_q <= level_d;
      pin_q   <= level_d ^ inv_i;
    end
  end

  assign level_o = level_q;
  assign pin_o   = pin_q;

  // R6
  set_op_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SET) |=> level_q);
  // R9
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_q == (level_q ^ $past(inv_i))));
endmodule

// File: rtl/cmp_action_out.sv
module cmp_action_out
  import cmp_act_pkg::*;
#(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACT_W-1:0] act_sel,
  input  logic             start_i,
  input  logic             tmo_i,
  input  logic             inv_i,
  output logic             pin_o
);
  pin_op_e op;
  logic    level;

  cmp_act_decode u_dec (
    .act_sel (act_sel),
    .start_i (start_i),
    .tmo_i   (tmo_i),
    .op_o    (op)
  );

  cmp_act_level #(.RST_LEVEL(RST_LEVEL)) u_lvl (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op),
    .inv_i   (inv_i),
    .level_o (level),
    .pin_o   (pin_o)
  );

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act_sel == 3'd0) |=> $stable(level));
  // R3
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (act_sel == 3'd1 && tmo_i) |=> (level != $past(level)));
  // R7
  start_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && tmo_i && act_sel[2]) |=> (level == ~$past(act_sel[0])));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !tmo_i) |=> $stable(level));
endmodule

// File: tb/cmp_action_out_tb.sv
module cmp_action_out_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] act = 3'd0;
  logic       start = 1'b0;
  logic       tmo = 1'b0;
  logic       inv = 1'b0;
  logic       pin;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_action_out dut_i (
    .clk(clk), .rst(rst), .act_sel(act), .start_i(start),
    .tmo_i(tmo), .inv_i(inv), .pin_o(pin)
  );

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (pin !== exp) begin
      n_bad++;
      $display("FAIL %s: pin_o=%b expected %b", tag, pin, exp);
    end
  endtask

  // one event cycle, returns at the falling edge after the sampling edge
  task automatic ev(input logic [2:0] a, input logic s, input logic t);
    @(negedge clk); act = a; start = s; tmo = t;
    @(negedge clk); start = 1'b0; tmo = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; inv = 1'b1;
    @(negedge clk); check(1'b0, "R1 reset with invert");
    inv = 1'b0;
    @(negedge clk); check(1'b0, "R1 reset");
    rst = 1'b0;
    @(negedge clk); check(1'b0, "R1 after release");
  endtask

  task automatic t_hold;
    ev(3'd3, 1'b0, 1'b1); check(1'b1, "R4 code3 sets");
    ev(3'd0, 1'b0, 1'b1); check(1'b1, "R2 code0 time-out");
    ev(3'd0, 1'b1, 1'b0); check(1'b1, "R2 code0 start");
  endtask

  task automatic t_toggle;
    ev(3'd1, 1'b0, 1'b1); check(1'b0, "R3 toggle 1");
    ev(3'd1, 1'b0, 1'b1); check(1'b1, "R3 toggle 2");
    ev(3'd1, 1'b1, 1'b0); check(1'b1, "R3 start ignored");
  endtask

  task automatic t_clr_set;
    ev(3'd2, 1'b0, 1'b1); check(1'b0, "R4 code2 clears");
    ev(3'd2, 1'b0, 1'b1); check(1'b0, "R4 code2 again");
    ev(3'd3, 1'b1, 1'b0); check(1'b0, "R4 code3 start ignored");
    ev(3'd3, 1'b0, 1'b1); check(1'b1, "R4 code3 sets");
    ev(3'd2, 1'b1, 1'b0); check(1'b1, "R4 code2 start ignored");
  endtask

  task automatic t_start_tog;
    ev(3'd5, 1'b1, 1'b0); check(1'b0, "R5 code5 start clears");
    ev(3'd5, 1'b0, 1'b1); check(1'b1, "R5 code5 toggle");
    ev(3'd4, 1'b1, 1'b0); check(1'b1, "R5 code4 start sets");
    ev(3'd4, 1'b0, 1'b1); check(1'b0, "R5 code4 toggle 1");
    ev(3'd4, 1'b0, 1'b1); check(1'b1, "R5 code4 toggle 2");
  endtask

  task automatic t_start_fixed;
    ev(3'd6, 1'b1, 1'b0); check(1'b1, "R6 code6 start sets");
    ev(3'd6, 1'b0, 1'b1); check(1'b0, "R6 code6 clears");
    ev(3'd6, 1'b0, 1'b1); check(1'b0, "R6 code6 stays clear");
    ev(3'd7, 1'b1, 1'b0); check(1'b0, "R6 code7 start clears");
    ev(3'd7, 1'b0, 1'b1); check(1'b1, "R6 code7 sets");
    ev(3'd7, 1'b1, 1'b0); check(1'b0, "R6 code7 restart clears");
  endtask

  task automatic t_collide;
    ev(3'd3, 1'b0, 1'b1); check(1'b1, "R7 prep high");
    ev(3'd4, 1'b1, 1'b1); check(1'b1, "R7 code4 start wins");
    ev(3'd2, 1'b0, 1'b1); check(1'b0, "R7 prep low");
    ev(3'd5, 1'b1, 1'b1); check(1'b0, "R7 code5 start wins");
    ev(3'd1, 1'b1, 1'b1); check(1'b1, "R7 code1 toggles");
  endtask

  task automatic t_change;
    @(negedge clk); act = 3'd2;
    @(negedge clk); act = 3'd5;
    @(negedge clk); check(1'b1, "R8 code change alone");
    ev(3'd2, 1'b0, 1'b1); check(1'b0, "R8 new code applies");
  endtask

  task automatic t_invert;
    @(negedge clk); inv = 1'b1;
    #1 check(1'b0, "R9 invert not yet");
    @(negedge clk); check(1'b1, "R9 inverted low level");
    ev(3'd1, 1'b0, 1'b1); check(1'b0, "R9 inverted high level");
    @(negedge clk); inv = 1'b0;
    @(negedge clk); check(1'b1, "R9 polarity restored");
  endtask

  task automatic t_latency;
    @(negedge clk); act = 3'd1; tmo = 1'b1;
    #1 check(1'b1, "R10 before edge");
    @(negedge clk); tmo = 1'b0;
    check(1'b0, "R10 after edge");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run stuck, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hold();
    t_toggle();
    t_clr_set();
    t_start_tog();
    t_start_fixed();
    t_collide();
    t_change();
    t_invert();
    t_latency();
    t_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule